// File: doc/BRIEF.md
# FPGA Configuration and Reset Sequencer

This block brings up a downstream FPGA that loads itself from a configuration EEPROM shared with the host CPU. It then releases the devices that depend on that FPGA from reset. A single start request runs the whole flow in hardware. The sequencer first gives the EEPROM bus to the FPGA and enables the program path. It pulses the program line and waits for the FPGA's init handshake, then for its done flag. Each wait is a bounded poll. Afterwards it gives the EEPROM back to the host, releases the downstream resets together, waits a settle time and reports ready.

All delays count a one-microsecond tick input, so the block runs at any clock frequency. The init and done inputs come from another clock domain and pass through two-register synchronizers. A stage that times out raises its own sticky error bit. The sequence then carries on, so the host always gets its EEPROM back and the resets are always released. Default parameters give a 10 µs poll interval, 10000 init polls, 500000 done polls and a 50 ms settle time.

Top module: `fpga_cfg_seq`

## Requirements
- R1: After reset the outputs sit at their idle levels: rom_host_n_o=0 (host owns the EEPROM), cfg_sel_n_o=1, prog_n_o=1, all dev_rst_n_o bits 0 (resets asserted), busy_o=0, ready_o=0, err_init_o=0, err_done_o=0.
- R2: A start_i accepted while idle or ready takes effect on the next clock edge. After that edge rom_host_n_o=1 (FPGA owns the EEPROM), busy_o=1, ready_o=0, both error bits are 0 and all resets are asserted. cfg_sel_n_o stays high for exactly that one cycle.
- R3: cfg_sel_n_o goes low one cycle after the bus handover, and prog_n_o goes low one cycle after that. prog_n_o is never low unless cfg_sel_n_o is low and rom_host_n_o is 1.
- R4: While prog_n_o is low, the synchronized fpga_init_n_i is sampled once every POLL_US ticks. The first sample falls POLL_US ticks after prog_n_o falls. prog_n_o returns high at the first sample that reads 0, so prog_n_o stays low for k·POLL_US ticks when the k-th sample is the first low one.
- R5: If INIT_POLLS samples all read 1, err_init_o is set at the last sample and prog_n_o is released anyway, after INIT_POLLS·POLL_US ticks.
- R6: After prog_n_o rises, the synchronized fpga_done_i is sampled once every POLL_US ticks, the first sample POLL_US ticks after the rise. The first sample that reads 1 ends the phase. At that edge cfg_sel_n_o goes high and rom_host_n_o goes to 0, both together.
- R7: If DONE_POLLS samples all read 0, err_done_o is set and the phase ends as in R6 after DONE_POLLS·POLL_US ticks.
- R8: All dev_rst_n_o bits stay 0 from the accepted start until the configuration phase ends. They all go to 1 on the same edge that cfg_sel_n_o rises, and they always hold equal values.
- R9: ready_o rises SETTLE_US ticks after the resets are released, and busy_o falls on that same edge. The ready state holds its outputs until the next accepted start.
- R10: Time advances only on cycles with us_tick_i=1. Cycles without a tick extend the current phase one-for-one.
- R11: A start_i that arrives while busy_o=1 has no effect on any output or phase length.
- R12: err_init_o and err_done_o are independent and sticky. Both may be set in the same run. Both keep their values while not busy and are cleared only by the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Request to run the configuration sequence |
| us_tick_i | input | 1 | One-cycle pulse every microsecond |
| fpga_init_n_i | input | 1 | FPGA init handshake, active low, asynchronous |
| fpga_done_i | input | 1 | FPGA configuration done, active high, asynchronous |
| rom_host_n_o | output | 1 | EEPROM bus owner: 0 host CPU, 1 FPGA |
| cfg_sel_n_o | output | 1 | Configuration select, active low |
| prog_n_o | output | 1 | FPGA program line, active low |
| dev_rst_n_o | output | NUM_RST | Downstream device resets, active low |
| busy_o | output | 1 | Sequence in progress |
| ready_o | output | 1 | Sequence finished and settle time elapsed |
| err_init_o | output | 1 | Sticky init-handshake timeout |
| err_done_o | output | 1 | Sticky done timeout |

## Verification
All outputs come from registers loaded from the next state, so each one changes on the same edge as the state. The bus handover is visible one edge after start is sampled, config select one edge later and the program line one edge after that. An init or done sample falls exactly POLL_US ticks after its phase began or after the previous sample, and ready follows SETTLE_US ticks after release. The bench drives a tick on every cycle (except in one frozen window). It observes the ports at falling edges and counts how many samples each phase lasts, then compares the counts with k·POLL_US, the timeout limits and SETTLE_US. Init and done stimuli change right after the edge one poll interval before the sample they target, which leaves the two-register synchronizer time to settle, and the earlier samples still see the old level.

// File: rtl/fcs_pkg.sv
`timescale 1ns/1ps
package fcs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_BUS    = 3'd1,
    ST_CSEL   = 3'd2,
    ST_INIT   = 3'd3,
    ST_DONE   = 3'd4,
    ST_SETTLE = 3'd5,
    ST_READY  = 3'd6
  } fcs_state_e;

  // Pin levels owned by each state; registered from the next state.
  typedef struct packed {
    logic rom_host_n;
    logic cfg_sel_n;
    logic prog_n;
    logic rst_hold;
    logic busy;
    logic ready;
  } fcs_pins_t;

  function automatic fcs_pins_t fcs_decode(input fcs_state_e st);
    fcs_pins_t p;
    p.rom_host_n = 1'b0;
    p.cfg_sel_n  = 1'b1;
    p.prog_n     = 1'b1;
    p.rst_hold   = 1'b1;
    p.busy       = 1'b0;
    p.ready      = 1'b0;
    case (st)
      ST_BUS: begin
        p.rom_host_n = 1'b1;
        p.busy       = 1'b1;
      end
      ST_CSEL, ST_DONE: begin
        p.rom_host_n = 1'b1;
        p.cfg_sel_n  = 1'b0;
        p.busy       = 1'b1;
      end
      ST_INIT: begin
        p.rom_host_n = 1'b1;
        p.cfg_sel_n  = 1'b0;
        p.prog_n     = 1'b0;
        p.busy       = 1'b1;
      end
      ST_SETTLE: begin
        p.rst_hold = 1'b0;
        p.busy     = 1'b1;
      end
      ST_READY: begin
        p.rst_hold = 1'b0;
        p.ready    = 1'b1;
      end
      default: ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/fcs_sync.sv
`timescale 1ns/1ps
module fcs_sync #(
  parameter int               WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[b];
        stab_q <= RST_VAL[b];
      end else begin
        meta_q <= d_i[b];
        stab_q <= meta_q;
      end
    end
    assign q_o[b] = stab_q;
  end

endmodule

// File: rtl/fcs_interval.sv
`timescale 1ns/1ps
module fcs_interval #(
  parameter int PERIOD = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clr_i,
  input  logic tick_i,
  output logic due_o
);

  localparam int           CW   = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign due_o   = run_i && tick_i && at_last;
  assign cnt_en  = clr_i || (run_i && tick_i);

  always_comb begin
    if (clr_i) begin
      cnt_d = '0;
    end else if (at_last) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/fcs_pollcnt.sv
`timescale 1ns/1ps
module fcs_pollcnt #(
  parameter int CW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic [CW-1:0] last_idx_i,
  output logic          last_o
);

  logic [CW-1:0] taken_q;
  logic [CW-1:0] taken_d;
  logic          taken_en;

  // Samples already taken in this phase; the current one is the last allowed.
  assign last_o   = (taken_q == last_idx_i);
  assign taken_en = clr_i || step_i;

  always_comb begin
    if (clr_i) begin
      taken_d = '0;
    end else begin
      taken_d = taken_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q <= '0;
    end else if (taken_en) begin
      taken_q <= taken_d;
    end
  end

endmodule

// File: rtl/fpga_cfg_seq.sv
`timescale 1ns/1ps
module fpga_cfg_seq
  import fcs_pkg::*;
#(
  parameter int POLL_US    = 10,
  parameter int INIT_POLLS = 10000,
  parameter int DONE_POLLS = 500000,
  parameter int SETTLE_US  = 50000,
  parameter int NUM_RST    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               us_tick_i,
  input  logic               fpga_init_n_i,
  input  logic               fpga_done_i,
  output logic               rom_host_n_o,
  output logic               cfg_sel_n_o,
  output logic               prog_n_o,
  output logic [NUM_RST-1:0] dev_rst_n_o,
  output logic               busy_o,
  output logic               ready_o,
  output logic               err_init_o,
  output logic               err_done_o
);

  localparam int MAX_POLLS = (INIT_POLLS > DONE_POLLS) ? INIT_POLLS : DONE_POLLS;
  localparam int PCW       = $clog2(MAX_POLLS + 1);
  localparam logic [PCW-1:0] INIT_LAST = PCW'(INIT_POLLS - 1);
  localparam logic [PCW-1:0] DONE_LAST = PCW'(DONE_POLLS - 1);

  fcs_state_e state_q;
  fcs_state_e state_d;
  logic       state_en;
  fcs_pins_t  pins_q;

  logic [1:0] async_in;
  logic [1:0] sync_in;
  logic       init_n_s;
  logic       done_s;

  logic           poll_run;
  logic           poll_due;
  logic           poll_last;
  logic [PCW-1:0] poll_limit;
  logic           settle_run;
  logic           settle_due;

  logic accept;
  logic set_err_init;
  logic set_err_done;
  logic err_init_q;
  logic err_done_q;
  logic err_init_d;
  logic err_done_d;
  logic err_init_en;
  logic err_done_en;

  // ---------------- input synchronizers ----------------
  assign async_in = {fpga_done_i, fpga_init_n_i};

  fcs_sync #(
    .WIDTH  (2),
    .RST_VAL(2'b01)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (async_in),
    .q_o  (sync_in)
  );

  assign init_n_s = sync_in[0];
  assign done_s   = sync_in[1];

  // ---------------- timers ----------------
  assign state_en   = (state_d != state_q);
  assign poll_run   = (state_q == ST_INIT) || (state_q == ST_DONE);
  assign settle_run = (state_q == ST_SETTLE);
  assign poll_limit = (state_q == ST_INIT) ? INIT_LAST : DONE_LAST;

  fcs_interval #(
    .PERIOD(POLL_US)
  ) u_poll_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (poll_run),
    .clr_i (state_en),
    .tick_i(us_tick_i),
    .due_o (poll_due)
  );

  fcs_interval #(
    .PERIOD(SETTLE_US)
  ) u_settle_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (settle_run),
    .clr_i (state_en),
    .tick_i(us_tick_i),
    .due_o (settle_due)
  );

  fcs_pollcnt #(
    .CW(PCW)
  ) u_polls (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (state_en),
    .step_i    (poll_due),
    .last_idx_i(poll_limit),
    .last_o    (poll_last)
  );

  // ---------------- next-state logic ----------------
  assign accept = start_i && ((state_q == ST_IDLE) || (state_q == ST_READY));

  always_comb begin
    state_d      = state_q;
    set_err_init = 1'b0;
    set_err_done = 1'b0;
    case (state_q)
      ST_IDLE, ST_READY: begin
        if (start_i) state_d = ST_BUS;
      end
      ST_BUS:  state_d = ST_CSEL;
      ST_CSEL: state_d = ST_INIT;
      ST_INIT: begin
        if (poll_due) begin
          if (!init_n_s) begin
            state_d = ST_DONE;
          end else if (poll_last) begin
            state_d      = ST_DONE;
            set_err_init = 1'b1;
          end
        end
      end
      ST_DONE: begin
        if (poll_due) begin
          if (done_s) begin
            state_d = ST_SETTLE;
          end else if (poll_last) begin
            state_d      = ST_SETTLE;
            set_err_done = 1'b1;
          end
        end
      end
      ST_SETTLE: begin
        if (settle_due) state_d = ST_READY;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // ---------------- error flags ----------------
  assign err_init_en = accept || set_err_init;
  assign err_done_en = accept || set_err_done;
  assign err_init_d  = set_err_init;
  assign err_done_d  = set_err_done;

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pins_q  <= fcs_decode(ST_IDLE);
    end else if (state_en) begin
      state_q <= state_d;
      pins_q  <= fcs_decode(state_d);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_init_q <= 1'b0;
    end else if (err_init_en) begin
      err_init_q <= err_init_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_done_q <= 1'b0;
    end else if (err_done_en) begin
      err_done_q <= err_done_d;
    end
  end

  // ---------------- outputs ----------------
  assign rom_host_n_o = pins_q.rom_host_n;
  assign cfg_sel_n_o  = pins_q.cfg_sel_n;
  assign prog_n_o     = pins_q.prog_n;
  assign busy_o       = pins_q.busy;
  assign ready_o      = pins_q.ready;
  assign err_init_o   = err_init_q;
  assign err_done_o   = err_done_q;

  for (genvar r = 0; r < NUM_RST; r++) begin : g_rst
    assign dev_rst_n_o[r] = ~pins_q.rst_hold;
  end

endmodule

// File: rtl/fcs_chk.sv
`timescale 1ns/1ps
module fcs_chk #(
  parameter int NUM_RST = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_i,
  input logic               rom_host_n_o,
  input logic               cfg_sel_n_o,
  input logic               prog_n_o,
  input logic [NUM_RST-1:0] dev_rst_n_o,
  input logic               busy_o,
  input logic               ready_o,
  input logic               err_init_o,
  input logic               err_done_o
);

  a_r2_start_grabs_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && rom_host_n_o && cfg_sel_n_o && !ready_o));

  a_r3_prog_needs_csel: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n_o |-> (!cfg_sel_n_o && rom_host_n_o));

  a_r6_handback: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_sel_n_o) |-> (!rom_host_n_o && prog_n_o));

  a_r8_rst_held_in_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_sel_n_o |-> (dev_rst_n_o == '0));

  a_r8_rst_together: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rst_n_o == '0) || (dev_rst_n_o == '1));

  a_r9_ready_levels: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (!busy_o && (dev_rst_n_o == '1) && !rom_host_n_o && cfg_sel_n_o && prog_n_o));

  a_r12_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (!err_init_o && !err_done_o));

  a_r12_sticky_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(err_init_o) && $stable(err_done_o)));

endmodule

bind fpga_cfg_seq fcs_chk #(.NUM_RST(NUM_RST)) u_fcs_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .rom_host_n_o(rom_host_n_o),
  .cfg_sel_n_o (cfg_sel_n_o),
  .prog_n_o    (prog_n_o),
  .dev_rst_n_o (dev_rst_n_o),
  .busy_o      (busy_o),
  .ready_o     (ready_o),
  .err_init_o  (err_init_o),
  .err_done_o  (err_done_o)
);

// File: tb/tb_fpga_cfg_seq.sv
`timescale 1ns/1ps
module tb_fpga_cfg_seq;

  localparam int P  = 3;
  localparam int IP = 4;
  localparam int DP = 5;
  localparam int S  = 7;
  localparam int NR = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic          tick;
  logic          init_n;
  logic          done;
  logic          rom_host_n;
  logic          cfg_sel_n;
  logic          prog_n;
  logic [NR-1:0] dev_rst_n;
  logic          busy;
  logic          ready;
  logic          err_init;
  logic          err_done;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  fpga_cfg_seq #(
    .POLL_US   (P),
    .INIT_POLLS(IP),
    .DONE_POLLS(DP),
    .SETTLE_US (S),
    .NUM_RST   (NR)
  ) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .us_tick_i    (tick),
    .fpga_init_n_i(init_n),
    .fpga_done_i  (done),
    .rom_host_n_o (rom_host_n),
    .cfg_sel_n_o  (cfg_sel_n),
    .prog_n_o     (prog_n),
    .dev_rst_n_o  (dev_rst_n),
    .busy_o       (busy),
    .ready_o      (ready),
    .err_init_o   (err_init),
    .err_done_o   (err_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // k: index of first low init sample (k>IP never); j: same for done.
  task automatic run_seq(input int k, input int j, input int frz, input bit poke);
    int  n_rom = 0, n_cs = 0, n_prog = 0, n_done = 0, n_settle = 0;
    int  guard = 0, v_busy = 0, v_rst = 0;
    bit  seen_prog = 0;
    int  kk = (k > IP) ? IP : k;
    int  jj = (j > DP) ? DP : j;
    init_n = 1'b1;
    done   = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2 / R12: state right after the accepting edge
    chk("R2 busy after start", int'(busy), 1);
    chk("R2 bus to fpga", int'(rom_host_n), 1);
    chk("R2 ready cleared", int'(ready), 0);
    chk("R12 errors cleared", int'({err_init, err_done}), 0);
    chk("R8 resets asserted", int'(dev_rst_n), 0);
    while (!ready && guard < 400) begin
      guard++;
      start = 1'b0;
      if (!busy) v_busy++;
      if (rom_host_n && cfg_sel_n && prog_n && !seen_prog) n_rom++;
      if (!cfg_sel_n && prog_n && !seen_prog) n_cs++;
      if (!prog_n) begin
        seen_prog = 1'b1;
        n_prog++;
        if (k <= IP && n_prog == (k - 1) * P + 1) init_n = 1'b0;
        if (frz > 0 && n_prog == 1) tick = 1'b0;
        if (frz > 0 && n_prog == 1 + frz) tick = 1'b1;
      end
      if (seen_prog && prog_n && !cfg_sel_n) begin
        n_done++;
        if (j <= DP && n_done == (j - 1) * P + 1) done = 1'b1;
        if (poke && n_done == 1) start = 1'b1;
      end
      if (seen_prog && cfg_sel_n && !rom_host_n && dev_rst_n == '1) n_settle++;
      if (!cfg_sel_n && dev_rst_n != '0) v_rst++;
      @(negedge clk);
    end
    start = 1'b0;
    chk("R9 sequence reached ready", int'(guard < 400), 1);
    chk("R2 one cycle bus before csel", n_rom, 1);
    chk("R3 one cycle csel before prog", n_cs, 1);
    if (frz > 0) chk("R10 prog low length with frozen ticks", n_prog, kk * P + frz);
    else if (k > IP) chk("R5 prog low length on init timeout", n_prog, kk * P);
    else chk("R4 prog low length", n_prog, kk * P);
    chk("R5 init error flag", int'(err_init), int'(k > IP));
    if (poke) chk("R11 done phase length with ignored start", n_done, jj * P);
    else if (j > DP) chk("R7 done phase length on timeout", n_done, jj * P);
    else chk("R6 done phase length", n_done, jj * P);
    chk("R7 done error flag", int'(err_done), int'(j > DP));
    chk("R9 settle length", n_settle, S);
    chk("R11 busy held through run", v_busy, 0);
    chk("R8 resets held during config", v_rst, 0);
    chk("R9 ready idle levels", int'({busy, rom_host_n, cfg_sel_n, prog_n}), 4'b0011);
    chk("R8 resets released", int'(dev_rst_n), (1 << NR) - 1);
    repeat (5) @(negedge clk);
    chk("R9 ready holds", int'(ready), 1);
    chk("R12 errors sticky", int'({err_init, err_done}), int'({k > IP, j > DP}));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n  = 1'b0;
    start  = 1'b0;
    tick   = 1'b1;
    init_n = 1'b1;
    done   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: idle levels after reset
    chk("R1 rom host", int'(rom_host_n), 0);
    chk("R1 csel high", int'(cfg_sel_n), 1);
    chk("R1 prog high", int'(prog_n), 1);
    chk("R1 resets asserted", int'(dev_rst_n), 0);
    chk("R1 status clear", int'({busy, ready, err_init, err_done}), 0);
    for (int k = 1; k <= IP + 1; k++) begin
      for (int j = 1; j <= DP + 1; j++) begin
        run_seq(k, j, 0, ((k + j) % 3) == 0);
      end
    end
    run_seq(1, 1, 20, 1'b0);
    run_seq(IP + 1, DP + 1, 0, 1'b1);
    run_seq(2, 3, 0, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule